// File: doc/BRIEF.md
# DRAM Reset Release Sequencer

This block brings a DRAM controller and its PHY out of reset in a fixed, staggered order after a single start pulse. It owns six active-high reset outputs: a bus-side and a core-side reset for the controller, the same pair for the PHY, and two PHY soft resets, one for the analog section and one for the digital section. The PHY resets release before the controller resets. The analog soft reset releases before the digital one. Each gap between steps is a whole number of microseconds.

A prescaler turns the system clock into a one-microsecond tick. Every wait interval is a parameter counted in those ticks. After the final interval the block raises a done flag. The flag stays high until a new start arrives. A start that arrives while a sequence is running has no effect. Every output comes straight from a flop, so the resets cannot glitch.

Parameter defaults are `CLKS_PER_US` = 125 and waits of 10, 10, 10, 10, 5 and 1 microseconds. Every wait parameter must be at least 1.

Top module: `dram_rst_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, and afterwards until a start is accepted, the four controller and PHY bus/core resets are 1, both soft resets are 0 and `done` is 0.
- R2: A start sampled while idle or done takes effect at that edge. All four bus/core resets go to 1, both soft resets go to 0 and `done` goes to 0.
- R3: `HOLD_US` microseconds after the accepting edge, the PHY bus and core resets go to 0. The controller resets stay at 1.
- R4: `PHY_US` microseconds later, the controller bus and core resets go to 0. The controller is never out of reset while either PHY reset is 1.
- R5: `CTL_US` microseconds later, both PHY soft resets (analog and digital) go to 1.
- R6: `SOFT_US` microseconds later, the analog soft reset goes to 0 and the digital soft reset stays at 1.
- R7: `ANA_US` microseconds after that, the digital soft reset goes to 0. The digital soft reset is never 0 while the analog one is 1.
- R8: `FIN_US` microseconds after the digital release, `done` goes to 1 with all six resets at 0. It stays 1 until the next start is accepted.
- R9: A start sampled while a sequence is running is ignored. The outputs and the timing of the remaining steps are unchanged.
- R10: One microsecond is exactly `CLKS_PER_US` clock cycles, so a W-microsecond step lasts exactly W*`CLKS_PER_US` cycles from edge to edge.
- R11: All outputs are driven directly by flops that reset synchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start request; sampled on each rising edge |
| ctl_bus_rst | output | 1 | Controller bus-side reset, active high |
| ctl_core_rst | output | 1 | Controller core reset, active high |
| phy_bus_rst | output | 1 | PHY bus-side reset, active high |
| phy_core_rst | output | 1 | PHY core reset, active high |
| phy_ana_soft_rst | output | 1 | PHY analog soft reset, active high |
| phy_dig_soft_rst | output | 1 | PHY digital soft reset, active high |
| done | output | 1 | Sequence complete; held until the next accepted start |

## Verification
Some ordering rules hold on every cycle, and the assertions check them there. The controller is never out of reset while the PHY is still in reset. The digital soft reset is never released ahead of the analog one. When `done` is high, every reset is low. A running sequence never jumps back to its first step. The tick never fires on two cycles in a row, and the microsecond counter stays under the current step's limit.

The exact cycle at which each step changes can only be shown by the bench's scenarios. Those scenarios sample every cycle of complete sequences, with distinct wait lengths, random start noise during a run, restarts from done, and a reset in the middle of a run. Together they show the absolute step lengths and the fact that an ignored start leaves the timing untouched.

// File: rtl/rst_seq_pkg.sv
// Package: shared state encoding and output decode for the DRAM reset
// release sequencer. Assumes the step order is fixed: the order is the behaviour.
package rst_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HOLD    = 3'd1,
        ST_PHY_UP  = 3'd2,
        ST_CTL_UP  = 3'd3,
        ST_SOFT_ON = 3'd4,
        ST_ANA_UP  = 3'd5,
        ST_DIG_UP  = 3'd6,
        ST_DONE    = 3'd7
    } seq_state_e;

    typedef struct packed {
        logic done;
        logic dig_soft;
        logic ana_soft;
        logic phy_core;
        logic phy_bus;
        logic ctl_core;
        logic ctl_bus;
    } rst_vec_t;

    // Output levels that belong to each state.
    function automatic rst_vec_t decode_state(input seq_state_e st);
        rst_vec_t v;
        v = '0;
        case (st)
            ST_IDLE, ST_HOLD: begin
                v.ctl_bus  = 1'b1;
                v.ctl_core = 1'b1;
                v.phy_bus  = 1'b1;
                v.phy_core = 1'b1;
            end
            ST_PHY_UP: begin
                v.ctl_bus  = 1'b1;
                v.ctl_core = 1'b1;
            end
            ST_SOFT_ON: begin
                v.ana_soft = 1'b1;
                v.dig_soft = 1'b1;
            end
            ST_ANA_UP: v.dig_soft = 1'b1;
            ST_DONE:   v.done     = 1'b1;
            default:   v = '0;
        endcase
        return v;
    endfunction

    // Successor of a timed step.
    function automatic seq_state_e next_step(input seq_state_e st);
        case (st)
            ST_HOLD:    return ST_PHY_UP;
            ST_PHY_UP:  return ST_CTL_UP;
            ST_CTL_UP:  return ST_SOFT_ON;
            ST_SOFT_ON: return ST_ANA_UP;
            ST_ANA_UP:  return ST_DIG_UP;
            ST_DIG_UP:  return ST_DONE;
            default:    return st;
        endcase
    endfunction

endpackage

// File: rtl/rst_seq_tick.sv
// Module: microsecond tick prescaler. Emits a one-cycle tick every
// CLKS_PER_US clocks while run is high. clear restarts the count so the
// first tick of a sequence comes exactly CLKS_PER_US cycles after the clear.
// Assumes CLKS_PER_US >= 1.
module rst_seq_tick #(
    parameter int CLKS_PER_US = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int PCW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PCW-1:0] LAST = PCW'(CLKS_PER_US - 1);

    logic [PCW-1:0] pre_cnt;

    assign tick = run && (pre_cnt == LAST);

    // Prescale counter: restarts on clear, wraps at LAST while running.
    always_ff @(posedge clk) begin
        if (!rst_n)          pre_cnt <= '0;
        else if (clear)      pre_cnt <= '0;
        else if (tick)       pre_cnt <= '0;
        else if (run)        pre_cnt <= pre_cnt + PCW'(1);
    end

    generate
        if (CLKS_PER_US > 1) begin : g_gap_chk
            // R10: a tick is never followed by another tick on the next cycle.
            p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/rst_seq_timer.sv
// Module: step interval timer. Counts microsecond ticks and reports
// step_done on the tick that completes `limit` microseconds. clear
// restarts the count. Assumes limit >= 1 and is stable within a step.
module rst_seq_timer #(
    parameter int US_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            run,
    input  logic            tick,
    input  logic [US_W-1:0] limit,
    output logic            step_done
);
    logic [US_W-1:0] us_cnt;

    assign step_done = tick && (us_cnt == limit - US_W'(1));

    // Microsecond counter: cleared on start and at each completed step.
    always_ff @(posedge clk) begin
        if (!rst_n)          us_cnt <= '0;
        else if (clear)      us_cnt <= '0;
        else if (step_done)  us_cnt <= '0;
        else if (tick)       us_cnt <= us_cnt + US_W'(1);
    end

    // R10: within a running step the count never reaches the step limit.
    p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (us_cnt < limit));

endmodule

// File: rtl/dram_rst_seq.sv
// Module: DRAM reset release sequencer top. On an accepted start it
// asserts the controller and PHY bus/core resets, then releases the PHY,
// then the controller, then pulses the PHY soft resets (analog released
// before digital), and finally raises done. Every step length is a
// parameter in microseconds. Assumes all *_US parameters are >= 1. Every
// output is a flop (R11).
module dram_rst_seq
    import rst_seq_pkg::*;
#(
    parameter int CLKS_PER_US = 125,
    parameter int HOLD_US     = 10,
    parameter int PHY_US      = 10,
    parameter int CTL_US      = 10,
    parameter int SOFT_US     = 10,
    parameter int ANA_US      = 5,
    parameter int FIN_US      = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ctl_bus_rst,
    output logic ctl_core_rst,
    output logic phy_bus_rst,
    output logic phy_core_rst,
    output logic phy_ana_soft_rst,
    output logic phy_dig_soft_rst,
    output logic done
);
    localparam int MAX_A = (HOLD_US > PHY_US) ? HOLD_US : PHY_US;
    localparam int MAX_B = (CTL_US > SOFT_US) ? CTL_US : SOFT_US;
    localparam int MAX_C = (ANA_US > FIN_US) ? ANA_US : FIN_US;
    localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_US = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int US_W = $clog2(MAX_US + 1);

    seq_state_e      state, state_nxt;
    rst_vec_t        out_q;
    logic            busy, accept, tick, step_done;
    logic [US_W-1:0] limit;

    assign busy   = (state != ST_IDLE) && (state != ST_DONE);
    assign accept = start && !busy;

    // Select the wait length of the current step.
    always_comb begin
        case (state)
            ST_HOLD:    limit = US_W'(HOLD_US);
            ST_PHY_UP:  limit = US_W'(PHY_US);
            ST_CTL_UP:  limit = US_W'(CTL_US);
            ST_SOFT_ON: limit = US_W'(SOFT_US);
            ST_ANA_UP:  limit = US_W'(ANA_US);
            ST_DIG_UP:  limit = US_W'(FIN_US);
            default:    limit = US_W'(1);
        endcase
    end

    // Next-state choice: accept a start when not busy, else advance on step end.
    always_comb begin
        state_nxt = state;
        if (accept)                 state_nxt = ST_HOLD;
        else if (busy && step_done) state_nxt = next_step(state);
    end

    // State and output flops; outputs are decoded from the next state and registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            out_q <= decode_state(ST_IDLE);
        end else begin
            state <= state_nxt;
            out_q <= decode_state(state_nxt);
        end
    end

    rst_seq_tick #(
        .CLKS_PER_US (CLKS_PER_US)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .run   (busy),
        .tick  (tick)
    );

    rst_seq_timer #(
        .US_W (US_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .run       (busy),
        .tick      (tick),
        .limit     (limit),
        .step_done (step_done)
    );

    assign ctl_bus_rst      = out_q.ctl_bus;
    assign ctl_core_rst     = out_q.ctl_core;
    assign phy_bus_rst      = out_q.phy_bus;
    assign phy_core_rst     = out_q.phy_core;
    assign phy_ana_soft_rst = out_q.ana_soft;
    assign phy_dig_soft_rst = out_q.dig_soft;
    assign done             = out_q.done;

    // R2: an accepted start puts the block into the hold step with all four bus/core resets set.
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (state == ST_HOLD && ctl_bus_rst && ctl_core_rst
                              && phy_bus_rst && phy_core_rst && !done));

    // R4: the controller is never out of reset while the PHY is held.
    p_phy_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_core_rst || !ctl_bus_rst) |-> (!phy_core_rst && !phy_bus_rst));

    // R7: the digital soft reset is never released while the analog one is set.
    p_ana_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phy_ana_soft_rst |-> phy_dig_soft_rst);

    // R8: done means every reset is low.
    p_done_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(ctl_bus_rst || ctl_core_rst || phy_bus_rst || phy_core_rst
                   || phy_ana_soft_rst || phy_dig_soft_rst));

    // R8: done holds until a start arrives.
    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R9: a running sequence never falls back to its first step.
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state != ST_HOLD) |=> (state != ST_HOLD));

endmodule

// File: tb/tb_dram_rst_seq.sv
module tb_dram_rst_seq;
    localparam int P  = 4;
    localparam int W1 = 3;
    localparam int W2 = 4;
    localparam int W3 = 5;
    localparam int W4 = 6;
    localparam int W5 = 2;
    localparam int W6 = 1;
    localparam int B1 = W1 * P;
    localparam int B2 = B1 + W2 * P;
    localparam int B3 = B2 + W3 * P;
    localparam int B4 = B3 + W4 * P;
    localparam int B5 = B4 + W5 * P;
    localparam int B6 = B5 + W6 * P;
    // vector order {done, dig_soft, ana_soft, phy_core, phy_bus, ctl_core, ctl_bus}
    localparam logic [6:0] V_IDLE = 7'b0001111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ctl_bus_rst, ctl_core_rst, phy_bus_rst, phy_core_rst;
    logic phy_ana_soft_rst, phy_dig_soft_rst, done;
    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    dram_rst_seq #(
        .CLKS_PER_US (P),
        .HOLD_US (W1), .PHY_US (W2), .CTL_US (W3),
        .SOFT_US (W4), .ANA_US (W5), .FIN_US (W6)
    ) dut (
        .clk (clk), .rst_n (rst_n), .start (start),
        .ctl_bus_rst (ctl_bus_rst), .ctl_core_rst (ctl_core_rst),
        .phy_bus_rst (phy_bus_rst), .phy_core_rst (phy_core_rst),
        .phy_ana_soft_rst (phy_ana_soft_rst), .phy_dig_soft_rst (phy_dig_soft_rst),
        .done (done)
    );

    function automatic logic [6:0] actual();
        return {done, phy_dig_soft_rst, phy_ana_soft_rst, phy_core_rst,
                phy_bus_rst, ctl_core_rst, ctl_bus_rst};
    endfunction

    // Expected outputs k edges after the accepting edge (k = 0 is that edge).
    function automatic logic [6:0] exp_vec(input int k);
        if (k < B1) return 7'b0001111;
        if (k < B2) return 7'b0000011;
        if (k < B3) return 7'b0000000;
        if (k < B4) return 7'b0110000;
        if (k < B5) return 7'b0100000;
        if (k < B6) return 7'b0000000;
        return 7'b1000000;
    endfunction

    function automatic string exp_tag(input int k);
        string t;
        if (k < B1)      t = "R2";
        else if (k < B2) t = "R3";
        else if (k < B3) t = "R4";
        else if (k < B4) t = "R5";
        else if (k < B5) t = "R6";
        else if (k < B6) t = "R7";
        else             t = "R8";
        if (k == B1 || k == B2 || k == B3 || k == B4 || k == B5 || k == B6 ||
            k == B1 - 1 || k == B6 - 1)
            t = {t, " R10"};
        return t;
    endfunction

    task automatic chk(input logic [6:0] exp, input string tag);
        logic [6:0] a;
        a = actual();
        n_checks++;
        if (a !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", tag, a, exp, $time);
        end
    endtask

    // One full sequence; noise drives random starts while it runs (R9).
    task automatic run_seq(input bit noise, input int gap);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int k = 0; k <= B6 + gap; k++) begin
            chk(exp_vec(k), noise ? {exp_tag(k), " R9"} : exp_tag(k));
            start = (noise && k < B6 && ($urandom % 5 == 0)) ? 1'b1 : 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2468));
        // R1: reset state, R11: flops set synchronously
        repeat (3) @(posedge clk);
        @(negedge clk) chk(V_IDLE, "R1 R11");
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk) chk(V_IDLE, "R1");
        end
        // directed sequences: first run, then restart from done
        run_seq(1'b0, 3);
        run_seq(1'b0, 1);
        // random noise and random gaps
        for (int i = 0; i < 8; i++) run_seq(1'b1, 1 + int'($urandom % 8));
        // reset in the middle of a run
        begin
            int stop;
            stop = 1 + int'($urandom % (B6 - 2));
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            repeat (stop) @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk) chk(V_IDLE, "R1 mid-run reset");
            rst_n = 1'b1;
            repeat (B1 + 2) @(negedge clk);
            chk(V_IDLE, "R1 idle after reset");
        end
        run_seq(1'b0, 2);
        run_seq(1'b1, 4);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule